// File: doc/BRIEF.md
# Interrupt Context Save Stack

This unit keeps the small piece of processor state that has to survive an interrupt: a 4-bit bank selector and a 1-bit index enable flag. The core reads both from the live outputs and can overwrite them with a write strobe. When the interrupt logic accepts a request, the unit copies the live pair into a two-entry last-in, first-out store. In the same step it returns the live pair to zero, so the handler always starts from a known context. A return strobe copies the newest saved pair back into the live registers.

The store is only two entries deep. A third nested entry therefore cannot be unwound correctly. When that happens the unit keeps the two newest contexts, drops the oldest one and raises a sticky overflow flag. A return with nothing saved leaves the live pair alone and raises a sticky underflow flag. The depth output shows how many entries are valid.

All pins are plain control and status signals, sampled on the rising clock edge. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_ctx_stack`

## Requirements
- R1: While reset is asserted (rst_n low) and after it is released, bank_o, idx_en_o, depth_o, overflow_o and underflow_o are all zero.
- R2: When wr_en is high and neither irq_accept nor irq_return is high, bank_o and idx_en_o take wr_bank and wr_idx one cycle later.
- R3: An irq_accept without irq_return, at depth 0 or 1, stores the live pair as the newest entry, clears bank_o and idx_en_o to zero the next cycle, and raises depth_o by one.
- R4: An irq_return without irq_accept, at depth 1 or 2, loads the newest entry into bank_o and idx_en_o the next cycle and lowers depth_o by one, so the entries come back in reverse order of saving.
- R5: An irq_accept without irq_return at depth 2 drops the oldest entry, stores the live pair as the newest entry, clears the live pair, keeps depth_o at 2 and sets overflow_o.
- R6: overflow_o and underflow_o, once set, stay high until reset.
- R7: An irq_return without irq_accept at depth 0 leaves bank_o, idx_en_o and depth_o unchanged and sets underflow_o.
- R8: When irq_accept and irq_return are high in the same cycle, the return is done first and then the save. At depth 1 or 2 the stored entries and the depth stay the same and the live pair is cleared. At depth 0 underflow_o is set, the live pair is stored, depth_o becomes 1 and the live pair is cleared.
- R9: A write in the same cycle as irq_accept or irq_return is discarded, and a save stores the value held before that write.
- R10: depth_o never exceeds 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Core write strobe for the live pair |
| wr_bank | input | 4 | Bank value to write |
| wr_idx | input | 1 | Index enable value to write |
| irq_accept | input | 1 | Interrupt accepted: save the context |
| irq_return | input | 1 | Return from interrupt: restore the context |
| bank_o | output | 4 | Live bank register |
| idx_en_o | output | 1 | Live index enable flag |
| depth_o | output | 2 | Number of valid saved entries (0 to 2) |
| overflow_o | output | 1 | Sticky: a save found the store full |
| underflow_o | output | 1 | Sticky: a return found the store empty |

## Verification
The hardest state to reach is a third nested save followed by a full unwind. Only that sequence shows which entry was dropped, and only the two returns that follow make that visible at the ports. It also matters whether a save and a return in the same cycle leave the store intact. The directed part of the bench sweeps all 32 live values through two-level save and restore sequences, and then overfills the store with three distinct values. A long pseudo-random stream of saves, returns and writes, with frequent coincident strobes, is then checked step by step against an arithmetic model.

// File: rtl/irq_ctx_pkg.sv
package irq_ctx_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_SAVE = 2'd1,
    OP_LOAD = 2'd2,
    OP_BOTH = 2'd3
  } ctx_op_e;

  function automatic ctx_op_e ctx_decode(input logic save, input logic load);
    return ctx_op_e'({load, save});
  endfunction
endpackage

// File: rtl/irq_ctx_ctrl.sv
module irq_ctx_ctrl
  import irq_ctx_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             save_i,
  input  logic             load_i,
  input  logic             wr_i,
  output logic [CNT_W-1:0] depth_o,
  output logic             store_o,
  output logic             shift_o,
  output logic             restore_o,
  output logic             clear_o,
  output logic             write_o,
  output logic             ovf_o,
  output logic             unf_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  ctx_op_e          op;
  logic             empty, full;
  logic [CNT_W-1:0] depth_d;
  logic             ovf_d, unf_d;

  assign op    = ctx_decode(save_i, load_i);
  assign empty = (depth_o == '0);
  assign full  = (depth_o == FULL);

  always_comb begin
    depth_d   = depth_o;
    ovf_d     = ovf_o;
    unf_d     = unf_o;
    store_o   = 1'b0;
    shift_o   = 1'b0;
    restore_o = 1'b0;
    clear_o   = 1'b0;
    write_o   = 1'b0;
    unique case (op)
      OP_SAVE: begin
        clear_o = 1'b1;
        if (full) begin
          shift_o = 1'b1;
          ovf_d   = 1'b1;
        end else begin
          store_o = 1'b1;
          depth_d = depth_o + 1'b1;
        end
      end
      OP_LOAD: begin
        if (empty) begin
          unf_d = 1'b1;
        end else begin
          restore_o = 1'b1;
          depth_d   = depth_o - 1'b1;
        end
      end
      OP_BOTH: begin
        clear_o = 1'b1;
        if (empty) begin
          unf_d   = 1'b1;
          store_o = 1'b1;
          depth_d = CNT_W'(1);
        end
      end
      default: write_o = wr_i;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_o <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      depth_o <= depth_d;
      ovf_o   <= ovf_d;
      unf_o   <= unf_d;
    end
  end
endmodule

// File: rtl/irq_ctx_lifo.sv
module irq_ctx_lifo #(
  parameter int DEPTH = 2,
  parameter int CTX_W = 5,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] depth_i,
  input  logic             store_i,
  input  logic             shift_i,
  input  logic [CTX_W-1:0] din_i,
  output logic [CTX_W-1:0] top_o
);
  logic [CTX_W-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [CTX_W-1:0] from_above;
    if (g == DEPTH - 1) begin : g_last
      assign from_above = din_i;
    end else begin : g_mid
      assign from_above = slot_q[g+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (shift_i) begin
        slot_q[g] <= from_above;
      end else if (store_i && depth_i == CNT_W'(g)) begin
        slot_q[g] <= din_i;
      end
    end
  end

  always_comb begin
    top_o = slot_q[0];
    for (int i = 0; i < DEPTH; i++) begin
      if (depth_i == CNT_W'(i + 1)) top_o = slot_q[i];
    end
  end
endmodule

// File: rtl/irq_ctx_live.sv
module irq_ctx_live #(
  parameter int CTX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             restore_i,
  input  logic             write_i,
  input  logic [CTX_W-1:0] top_i,
  input  logic [CTX_W-1:0] wdata_i,
  output logic [CTX_W-1:0] live_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         live_o <= '0;
    else if (clear_i)   live_o <= '0;
    else if (restore_i) live_o <= top_i;
    else if (write_i)   live_o <= wdata_i;
  end
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack #(
  parameter int BANK_W = 4,
  parameter int DEPTH  = 2,
  localparam int CTX_W = BANK_W + 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic              wr_idx,
  input  logic              irq_accept,
  input  logic              irq_return,
  output logic [BANK_W-1:0] bank_o,
  output logic              idx_en_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              overflow_o,
  output logic              underflow_o
);
  logic             store, shift, restore, clear, write;
  logic [CTX_W-1:0] live, top;

  irq_ctx_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .save_i(irq_accept), .load_i(irq_return),
    .wr_i(wr_en), .depth_o(depth_o), .store_o(store), .shift_o(shift),
    .restore_o(restore), .clear_o(clear), .write_o(write),
    .ovf_o(overflow_o), .unf_o(underflow_o)
  );

  irq_ctx_lifo #(.DEPTH(DEPTH), .CTX_W(CTX_W)) lifo_i (
    .clk(clk), .rst_n(rst_n), .depth_i(depth_o), .store_i(store),
    .shift_i(shift), .din_i(live), .top_o(top)
  );

  irq_ctx_live #(.CTX_W(CTX_W)) live_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear), .restore_i(restore),
    .write_i(write), .top_i(top), .wdata_i({wr_bank, wr_idx}), .live_o(live)
  );

  assign bank_o   = live[CTX_W-1:1];
  assign idx_en_o = live[0];
endmodule

// File: rtl/irq_ctx_stack_chk.sv
module irq_ctx_stack_chk #(
  parameter int BANK_W = 4,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [BANK_W-1:0] wr_bank,
  input logic              wr_idx,
  input logic              irq_accept,
  input logic              irq_return,
  input logic [BANK_W-1:0] bank_o,
  input logic              idx_en_o,
  input logic [CNT_W-1:0]  depth_o,
  input logic              overflow_o,
  input logic              underflow_o
);
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !irq_accept && !irq_return) |=>
      (bank_o == $past(wr_bank) && idx_en_o == $past(wr_idx)));

  p_save_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_accept |=> (bank_o == '0 && !idx_en_o));

  p_full_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept && !irq_return && depth_o == CNT_W'(DEPTH)) |=>
      (overflow_o && depth_o == CNT_W'(DEPTH)));

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  p_unf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |=> underflow_o);

  p_empty_return_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_return && !irq_accept && depth_o == '0) |=>
      ($stable(bank_o) && $stable(idx_en_o) && underflow_o && depth_o == '0));

  p_both_depth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_accept && irq_return && depth_o != '0) |=> $stable(depth_o));

  p_depth_max_r10: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= CNT_W'(DEPTH));
endmodule

bind irq_ctx_stack irq_ctx_stack_chk #(.BANK_W(BANK_W), .DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
  .irq_accept(irq_accept), .irq_return(irq_return), .bank_o(bank_o),
  .idx_en_o(idx_en_o), .depth_o(depth_o), .overflow_o(overflow_o),
  .underflow_o(underflow_o)
);

// File: tb/irq_ctx_stack_tb_top.sv
module irq_ctx_stack_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_idx = 1'b0, irq_accept = 1'b0, irq_return = 1'b0;
  logic [3:0] wr_bank = '0;
  logic [3:0] bank_o;
  logic       idx_en_o, overflow_o, underflow_o;
  logic [1:0] depth_o;

  int checks = 0;
  int errors = 0;

  // bench model: live pair {bank, idx}, two slots, depth, flags
  logic [4:0] m_live, m_s0, m_s1;
  int         m_depth;
  logic       m_ovf, m_unf;

  always #2 clk = ~clk;

  irq_ctx_stack dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .irq_accept(irq_accept), .irq_return(irq_return), .bank_o(bank_o),
    .idx_en_o(idx_en_o), .depth_o(depth_o), .overflow_o(overflow_o),
    .underflow_o(underflow_o)
  );

  task automatic compare(string tag);
    logic [8:0] got, exp;
    got = {bank_o, idx_en_o, depth_o, overflow_o, underflow_o};
    exp = {m_live, 2'(m_depth), m_ovf, m_unf};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%b exp=%b (bank,idx,depth,ovf,unf)", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; irq_accept = 0; irq_return = 0; wr_en = 0;
    m_live = '0; m_s0 = '0; m_s1 = '0; m_depth = 0; m_ovf = 0; m_unf = 0;
    #1 compare("R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 compare("R1 after reset, R6 flags cleared");
  endtask

  task automatic step(bit a, bit r, bit w, logic [4:0] v);
    string tag;
    @(negedge clk);
    irq_accept = a; irq_return = r; wr_en = w; {wr_bank, wr_idx} = v;
    if (a && r) begin
      tag = "R8 coincident save/return";
      if (m_depth == 0) begin
        m_unf = 1; m_s0 = m_live; m_depth = 1;
      end
      m_live = '0;
    end else if (a) begin
      if (m_depth == 2) begin
        tag = "R5 save at full"; m_s0 = m_s1; m_s1 = m_live; m_ovf = 1;
      end else begin
        tag = "R3 save";
        if (m_depth == 0) m_s0 = m_live; else m_s1 = m_live;
        m_depth++;
      end
      m_live = '0;
      if (w) tag = {tag, " R9 write dropped"};
    end else if (r) begin
      if (m_depth == 0) begin
        tag = "R7 return when empty"; m_unf = 1;
      end else begin
        tag = "R4 return";
        m_depth--;
        m_live = (m_depth == 0) ? m_s0 : m_s1;
      end
      if (w) tag = {tag, " R9 write dropped"};
    end else if (w) begin
      tag = "R2 write"; m_live = v;
    end else tag = "R10 idle";
    @(posedge clk); #1 compare(tag);
    if (depth_o > 2) begin
      errors++; $display("FAIL R10 depth=%0d exp<=2", depth_o);
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // sweep every live value through two-level save/restore
    for (int v = 0; v < 32; v++) begin
      step(0, 0, 1, 5'(v));
      step(1, 0, 0, '0);
      step(0, 0, 1, 5'(v) ^ 5'h15);
      step(1, 0, 1, 5'(v) ^ 5'h0a);   // R9: write dropped, save keeps old
      step(0, 1, 0, '0);
      step(0, 1, 0, '0);
    end
    // overfill with three distinct values, then unwind
    step(0, 0, 1, 5'h03); step(1, 0, 0, '0);
    step(0, 0, 1, 5'h0c); step(1, 0, 0, '0);
    step(0, 0, 1, 5'h1e); step(1, 0, 0, '0);   // R5 drops 5'h03
    step(0, 1, 0, '0); step(0, 1, 0, '0);
    step(0, 1, 0, '0);                          // R7 empty
    step(0, 0, 0, '0);                          // R6 still set
    // coincident strobes at each depth
    do_reset();
    step(0, 0, 1, 5'h11); step(1, 1, 0, '0);    // R8 empty case
    step(0, 0, 1, 5'h07); step(1, 1, 0, '0);    // R8 depth 1
    step(0, 1, 0, '0);
    // pseudo-random stream
    do_reset();
    lfsr = 16'hace1;
    for (int n = 0; n < 3000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[1], lfsr[2] & lfsr[3], lfsr[4], lfsr[15:11]);
      if (n == 1500) do_reset();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule